// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor that keeps program and data in one memory and reaches that memory through a single synchronous port. Each instruction moves through a fixed series of steps between five special-purpose registers. A program counter supplies the fetch address. An address register drives the port. A data register holds whatever crosses the port in either direction. An instruction register feeds the decoder. An accumulator holds every arithmetic or logic result. Because one port serves both instruction fetches and data accesses, at most one memory access occurs in any cycle.

An instruction word is 16 bits. The opcode sits in bits [15:12] and a 12-bit address operand sits in bits [11:0]. The instruction set covers loading, storing, addition, subtraction, bitwise AND, OR and NOT, an unconditional jump and a jump taken when the accumulator is zero. A halt instruction parks the core until the next reset. The memory outside the core must return the addressed word in the cycle after the read strobe. The data-bus direction is split into a read-data input and a write-data output.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator, address, data and instruction registers, drops both strobes and `halted`, and restarts at the first fetch step. The first read strobe after reset comes in the second cycle after release, at address 0.
- R2: Fetch copies the program counter into the address register. In the next step it adds one to the program counter and asserts the read for that address. The following step captures the word into the data register.
- R3: Read and write strobes are never asserted together. Each executed instruction produces exactly one fetch read, plus one more read if it takes a data operand.
- R4: The instruction register is loaded only from the data register. Decode takes the opcode from bits [15:12] and the operand from bits [11:0]. LOAD (opcode 1) sets the accumulator to memory[operand].
- R5: ADD (3) and SUB (4) set the accumulator to accumulator plus or minus memory[operand], wrapping modulo 2^16.
- R6: AND (5) and OR (6) combine the accumulator bitwise with memory[operand]. NOT (7) inverts the accumulator and ignores the operand.
- R7: STORE (2) writes the accumulator to memory[operand] with a single-cycle write strobe.
- R8: JMP (8) loads the operand into the program counter during execute, so the next fetch reads from that address.
- R9: JZ (9) loads the operand into the program counter only when the accumulator is zero. Otherwise execution continues at the next sequential word.
- R10: HALT (0) raises `halted`. The core then stays in that state with both strobes low until reset.
- R11: Opcodes 10 to 15 change neither the accumulator nor memory, and execution proceeds to the next word.
- R12: An instruction with a data read (opcodes 1, 3, 4, 5, 6) takes 8 cycles. Every other instruction, including HALT up to the rise of `halted`, takes 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data, driven from the data register |
| mem_rdata | input | DATA_W | Read data from memory |
| halted | output | 1 | High while the core is parked after HALT |

## Verification
A corrupted program counter first shows up at the next fetch strobe, within six to eight cycles. It appears as a wrong address, a wrong total cycle count or a missing write, because the path a program takes decides which stores happen. A wrong accumulator or data register stays hidden until the next STORE puts it on the write data. For that reason the test programs store after every operation and after each branch point. A sequencer fault shows at once as a change in strobe counts or in instruction timing.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
   localparam int OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
   localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
   localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
   localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
   localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
   localparam logic [OPC_W-1:0] OP_AND   = 4'd5;
   localparam logic [OPC_W-1:0] OP_OR    = 4'd6;
   localparam logic [OPC_W-1:0] OP_NOT   = 4'd7;
   localparam logic [OPC_W-1:0] OP_JMP   = 4'd8;
   localparam logic [OPC_W-1:0] OP_JZ    = 4'd9;

   typedef enum logic [3:0] {
      ST_F0, ST_F1, ST_F2, ST_F3, ST_DEC,
      ST_RD, ST_CAP, ST_ALU, ST_WR, ST_EX, ST_HLT
   } state_e;

   typedef enum logic [2:0] {
      ALU_PASS, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOT
   } alu_op_e;

   typedef struct packed {
      logic    mem_src;
      logic    is_store;
      logic    is_jmp;
      logic    is_jz;
      logic    is_not;
      logic    is_halt;
      alu_op_e alu_op;
   } dec_t;
endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic [DATA_W-1:0] cir,
   output logic [ADDR_W-1:0] operand,
   output dec_t              dec
);
   logic [OPC_W-1:0] opc;

   assign opc     = cir[DATA_W-1 -: OPC_W];
   assign operand = cir[ADDR_W-1:0];

   always_comb begin
      dec = '0;
      dec.alu_op = ALU_PASS;
      case (opc)
         OP_HALT:  dec.is_halt = 1'b1;
         OP_LOAD:  begin dec.mem_src = 1'b1; dec.alu_op = ALU_PASS; end
         OP_STORE: dec.is_store = 1'b1;
         OP_ADD:   begin dec.mem_src = 1'b1; dec.alu_op = ALU_ADD; end
         OP_SUB:   begin dec.mem_src = 1'b1; dec.alu_op = ALU_SUB; end
         OP_AND:   begin dec.mem_src = 1'b1; dec.alu_op = ALU_AND; end
         OP_OR:    begin dec.mem_src = 1'b1; dec.alu_op = ALU_OR; end
         OP_NOT:   begin dec.is_not = 1'b1; dec.alu_op = ALU_NOT; end
         OP_JMP:   dec.is_jmp = 1'b1;
         OP_JZ:    dec.is_jz = 1'b1;
         default:  dec = '0;
      endcase
   end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   logic [DATA_W-1:0] addsub;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic              sub_sel;
         logic [DATA_W-1:0] b_x;
         assign sub_sel = (op == ALU_SUB);
         assign b_x     = sub_sel ? ~b : b;
         assign addsub  = a + b_x + DATA_W'(sub_sel);
      end else begin : g_split
         assign addsub = (op == ALU_SUB) ? (a - b) : (a + b);
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD,
         ALU_SUB:  y = addsub;
         ALU_AND:  y = a & b;
         ALU_OR:   y = a | b;
         ALU_NOT:  y = ~a;
         ALU_PASS: y = b;
         default:  y = a;
      endcase
   end
endmodule

// File: rtl/acc_core_seq.sv
module acc_core_seq
   import acc_core_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   mem_src,
   input  logic   is_store,
   input  logic   is_halt,
   output state_e st
);
   state_e st_nx;

   always_comb begin
      st_nx = st;
      case (st)
         ST_F0:  st_nx = ST_F1;
         ST_F1:  st_nx = ST_F2;
         ST_F2:  st_nx = ST_F3;
         ST_F3:  st_nx = ST_DEC;
         ST_DEC: begin
            if (mem_src)       st_nx = ST_RD;
            else if (is_store) st_nx = ST_WR;
            else               st_nx = ST_EX;
         end
         ST_RD:  st_nx = ST_CAP;
         ST_CAP: st_nx = ST_ALU;
         ST_ALU: st_nx = ST_F0;
         ST_WR:  st_nx = ST_F0;
         ST_EX:  st_nx = is_halt ? ST_HLT : ST_F0;
         ST_HLT: st_nx = ST_HLT;
         default: st_nx = ST_F0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= ST_F0;
      else     st <= st_nx;
   end
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int ADDR_W       = 12,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted
);
   localparam int FIELD_W = OPC_W + ADDR_W;

   generate
      if (DATA_W < FIELD_W) begin : g_bad_width
         $error("acc_core: DATA_W must hold opcode plus operand");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("acc_core: ADDR_W must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] pc, mar, operand;
   logic [DATA_W-1:0] mdr, cir, acc, alu_y;
   logic              acc_zero;
   dec_t              dec;
   state_e            st;

   acc_core_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .cir     (cir),
      .operand (operand),
      .dec     (dec)
   );

   acc_core_alu #(.DATA_W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op (dec.alu_op),
      .a  (acc),
      .b  (mdr),
      .y  (alu_y)
   );

   acc_core_seq u_seq (
      .clk      (clk),
      .rst      (rst),
      .mem_src  (dec.mem_src),
      .is_store (dec.is_store),
      .is_halt  (dec.is_halt),
      .st       (st)
   );

   assign acc_zero = (acc == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc  <= '0;
         mar <= '0;
         mdr <= '0;
         cir <= '0;
         acc <= '0;
      end else begin
         case (st)
            ST_F0:  mar <= pc;
            ST_F1:  pc  <= pc + 1'b1;
            ST_F2:  mdr <= mem_rdata;
            ST_F3:  cir <= mdr;
            ST_DEC: begin
               if (dec.mem_src || dec.is_store) mar <= operand;
               if (dec.is_store)                mdr <= acc;
            end
            ST_CAP: mdr <= mem_rdata;
            ST_ALU: acc <= alu_y;
            ST_EX: begin
               if (dec.is_jmp || (dec.is_jz && acc_zero)) pc <= operand;
               if (dec.is_not) acc <= alu_y;
            end
            default: ;
         endcase
      end
   end

   assign mem_addr  = mar;
   assign mem_rd    = (st == ST_F1) || (st == ST_RD);
   assign mem_wr    = (st == ST_WR);
   assign mem_wdata = mdr;
   assign halted    = (st == ST_HLT);
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input state_e            st,
   input logic              is_jz,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] mar,
   input logic [DATA_W-1:0] mdr,
   input logic [DATA_W-1:0] cir,
   input logic [DATA_W-1:0] acc,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              halted
);
   // R1
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (pc == '0 && acc == '0 && mar == '0 && mdr == '0 && cir == '0 && st == ST_F0));

   // R2
   mar_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_F0) |=> (mar == $past(pc)));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_F1) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

   // R3
   fetch_rd_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_F1) |-> (mem_rd && !mem_wr));

   // R3
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));

   // R4
   cir_load_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_F3) |=> (cir == $past(mdr)));

   // R7
   store_data_chk: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (mem_wdata == acc));

   // R9
   jz_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_EX && is_jz && acc != '0) |=> (pc == $past(pc)));

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && !mem_rd && !mem_wr));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .st        (st),
   .is_jz     (dec.is_jz),
   .pc        (pc),
   .mar       (mar),
   .mdr       (mdr),
   .cir       (cir),
   .acc       (acc),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_wdata (mem_wdata),
   .halted    (halted)
);

// File: tb/acc_core_tb.sv
`timescale 1ns/1ps
module acc_core_tb;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam int MEM_N = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          mem_rd, mem_wr, halted;
   logic [DW-1:0] mem_wdata, rdata_q;

   logic [DW-1:0] mem     [MEM_N];
   logic [DW-1:0] ref_mem [MEM_N];
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;

   int nchk = 0, nerr = 0;
   int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;

   always #4 clk = ~clk;

   acc_core u_dut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(rdata_q), .halted(halted)
   );

   // single-port memory with one cycle read latency
   always @(posedge clk) begin
      if (ld_en)       mem[ld_addr]  <= ld_data;
      else if (mem_wr) mem[mem_addr] <= mem_wdata;
      if (mem_rd)      rdata_q <= mem[mem_addr];
   end

   always @(negedge clk) begin
      if (!rst) begin
         if (mem_rd) rd_cnt++;
         if (mem_wr) wr_cnt++;
         if (mem_rd && mem_wr) both_cnt++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ins(input int op, input int arg);
      return {op[3:0], arg[AW-1:0]};
   endfunction

   task automatic put(input int addr, input logic [DW-1:0] data);
      ref_mem[addr] = data;
      @(negedge clk);
      ld_en = 1'b1; ld_addr = addr[AW-1:0]; ld_data = data;
   endtask

   // reference model from the requirements: cycles, reads and writes
   task automatic model_run(output int cyc, output int nrd, output int nwr);
      int pc = 0;
      logic [DW-1:0] acc = '0;
      cyc = 0; nrd = 0; nwr = 0;
      for (int step = 0; step < 500; step++) begin
         logic [DW-1:0] w = ref_mem[pc];
         int op = int'(w[15:12]);
         int a  = int'(w[11:0]);
         pc = (pc + 1) % MEM_N;
         nrd++;
         case (op)
            1: begin acc = ref_mem[a]; cyc += 8; nrd++; end
            2: begin ref_mem[a] = acc; cyc += 6; nwr++; end
            3: begin acc = acc + ref_mem[a]; cyc += 8; nrd++; end
            4: begin acc = acc - ref_mem[a]; cyc += 8; nrd++; end
            5: begin acc = acc & ref_mem[a]; cyc += 8; nrd++; end
            6: begin acc = acc | ref_mem[a]; cyc += 8; nrd++; end
            7: begin acc = ~acc; cyc += 6; end
            8: begin pc = a; cyc += 6; end
            9: begin if (acc == '0) pc = a; cyc += 6; end
            0: begin cyc += 6; break; end
            default: cyc += 6;
         endcase
      end
   endtask

   task automatic run_trial(input logic [DW-1:0] va, vb, vc, vd, ve, vz, vf,
                            input int nop_op, input int nop_arg);
      int cyc, e_cyc, e_rd, e_wr, rd0, wr0;
      rst = 1'b1;
      put(100, va); put(101, vb); put(102, vc); put(103, vd);
      put(104, ve); put(105, vz); put(106, vf);
      for (int k = 200; k < 208; k++) put(k, 16'hA500 + DW'(k));
      put(0, ins(1, 100));  put(1, ins(3, 101));  put(2, ins(2, 200));
      put(3, ins(4, 102));  put(4, ins(2, 201));  put(5, ins(5, 103));
      put(6, ins(2, 202));  put(7, ins(6, 104));  put(8, ins(2, 203));
      put(9, ins(7, 0));    put(10, ins(2, 204)); put(11, ins(1, 105));
      put(12, ins(9, 15));  put(13, ins(1, 106)); put(14, ins(2, 205));
      put(15, ins(nop_op, nop_arg)); put(16, ins(2, 206)); put(17, ins(8, 20));
      put(18, ins(2, 207)); put(19, ins(0, 0));   put(20, ins(0, 0));
      @(negedge clk);
      ld_en = 1'b0;
      rd_cnt = 0; wr_cnt = 0; both_cnt = 0;
      // R1: state held in reset
      chk("R1 reset strobes/halted", {mem_rd, mem_wr, halted}, 3'b000);
      chk("R1 reset address", 32'(mem_addr), 32'd0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      // R1: first read at address 0, second cycle after release
      chk("R1 first fetch addr/rd", {mem_rd, 20'(mem_addr)}, {1'b1, 20'd0});
      cyc = 1;
      while (!halted && cyc < 3000) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      model_run(e_cyc, e_rd, e_wr);
      chk("R12 cycles to halt", 32'(cyc), 32'(e_cyc));
      chk("R3 read strobe count", 32'(rd_cnt), 32'(e_rd));
      chk("R3 read+write overlap", 32'(both_cnt), 32'd0);
      chk("R7 write strobe count", 32'(wr_cnt), 32'(e_wr));
      chk("R5 ADD (R4 LOAD) @200", 32'(mem[200]), 32'(ref_mem[200]));
      chk("R5 SUB @201", 32'(mem[201]), 32'(ref_mem[201]));
      chk("R6 AND @202", 32'(mem[202]), 32'(ref_mem[202]));
      chk("R6 OR @203", 32'(mem[203]), 32'(ref_mem[203]));
      chk("R6 NOT @204", 32'(mem[204]), 32'(ref_mem[204]));
      chk("R9 JZ path @205", 32'(mem[205]), 32'(ref_mem[205]));
      chk("R11 unused opcode @206", 32'(mem[206]), 32'(ref_mem[206]));
      chk("R8 JMP skip @207", 32'(mem[207]), 32'(ref_mem[207]));
      rd0 = rd_cnt; wr0 = wr_cnt;
      repeat (16) @(negedge clk);
      chk("R10 halted holds", 32'(halted), 32'd1);
      chk("R10 no strobes while halted", 32'(rd_cnt - rd0 + wr_cnt - wr0), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog R10 actual no-finish expected finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // directed: wrap on ADD and SUB, JZ taken, opcode 10
      run_trial(16'hFFFF, 16'h0001, 16'h0001, 16'h0F0F, 16'h1200, 16'h0000, 16'h7777, 10, 0);
      // directed: JZ not taken, opcode 15 with full operand
      run_trial(16'h8000, 16'h8000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 15, 4095);
      for (int t = 0; t < 10; t++) begin
         logic [DW-1:0] z = ($urandom % 2 == 0) ? '0 : DW'($urandom);
         run_trial(DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom),
                   DW'($urandom), z, DW'($urandom),
                   10 + int'($urandom % 6), int'($urandom % 4096));
      end
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule